// File: doc/BRIEF.md
# Dual-Issue In-Order Issue Controller

This block governs a two-wide decode and issue stage that dispatches to three functional units and retires results through two write-back ports per cycle. Decoded instructions arrive as a pair. Each carries a destination register index with a write flag, two source register indices, a functional-unit selector, an execution latency in cycles, and a branch marker. Every cycle the controller decides which members of the held pair may be dispatched. It stalls whenever issuing would break program order in dispatch or in result write-back, create a register hazard, or pass an unresolved branch.

The controller keeps a pending bit for each architectural register and a busy countdown for each functional unit. It holds no operand values and no datapath. Its outputs report which slots were dispatched and to which units. When a unit's countdown expires, it reports the register indices being written back so that the surrounding pipeline can steer result buses. A new pair is accepted only once both slots of the current pair have been dispatched.

Top module: `dual_issue_ctrl`

## Requirements
- R1: After reset `in_ready` is 1 and `iss_valid` and `wb_valid` are 0. A pair is taken on a cycle with `in_valid` and `in_ready` both high. `in_ready` then stays 0 until both slots have issued, and it returns to 1 in the same cycle that `iss_valid` shows the last slot of the pair.
- R2: Slot 0 is the older instruction. Slot 1 never issues before slot 0. While slot 0 is still waiting, slot 1 waits even if slot 1 itself is free of hazards.
- R3: A unit is loaded with its instruction's latency L at issue and accepts nothing new until that countdown reaches zero. If both slots select the same unit, slot 1 shows on `iss_valid` exactly L+1 cycles after slot 0.
- R4: Results complete strictly in program order. An instruction issues only when no unit's remaining count exceeds its latency. Both slots issue together only if slot 1's latency is not below slot 0's. For independent slots on different units with L1 < L0, slot 1 shows L0-L1+1 cycles after slot 0.
- R5: An instruction whose source register is the destination of an unfinished older instruction waits until that write-back. Within a pair this delays slot 1 by L0+1 cycles. Across pairs, the dependent instruction dispatches in the cycle after the write-back edge.
- R6: An instruction whose destination register is still pending waits until that register's write-back. Within a pair this delays slot 1 by L0+1 cycles.
- R7: While a branch is in flight, nothing issues. A slot 1 paired with a branch in slot 0 issues L0+1 cycles after the branch.
- R8: An instruction with latency L shows on `wb_valid` exactly L cycles after it showed on `iss_valid`, with its destination on the write-back register output. When two results finish together, port 0 carries the older one and port 1 the younger. `wb_valid[1]` is never set without `wb_valid[0]`. An instruction whose write flag is 0 produces no write-back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | A decoded pair is offered |
| in_ready | output | 1 | Both decode slots are empty; the offered pair is taken |
| s0_dst | input | 4 | Older slot destination register |
| s0_wr | input | 1 | Older slot writes its destination |
| s0_src_a | input | 4 | Older slot first source register |
| s0_src_b | input | 4 | Older slot second source register |
| s0_unit | input | 2 | Older slot functional unit (0 to 2) |
| s0_lat | input | 3 | Older slot latency in cycles (1 or more) |
| s0_br | input | 1 | Older slot is a branch |
| s1_dst | input | 4 | Younger slot destination register |
| s1_wr | input | 1 | Younger slot writes its destination |
| s1_src_a | input | 4 | Younger slot first source register |
| s1_src_b | input | 4 | Younger slot second source register |
| s1_unit | input | 2 | Younger slot functional unit (0 to 2) |
| s1_lat | input | 3 | Younger slot latency in cycles (1 or more) |
| s1_br | input | 1 | Younger slot is a branch |
| iss_valid | output | 2 | Bit i set: slot i was dispatched at the last edge |
| iss_unit0 | output | 2 | Unit of slot 0 when `iss_valid[0]` is set |
| iss_unit1 | output | 2 | Unit of slot 1 when `iss_valid[1]` is set |
| wb_valid | output | 2 | Write-back ports carrying a result this cycle |
| wb_reg0 | output | 4 | Register written on port 0 (older result) |
| wb_reg1 | output | 4 | Register written on port 1 (younger result) |

## Verification
The assertions assume a latency of at least one cycle and a unit selector below three. Under these assumptions, every in-flight countdown is cleared by write-back, and no more than one pair finishes on any edge. The stimulus keeps every latency between 1 and 4 and every unit index between 0 and 2. Before the next pair is offered, it lets the machine drain, except in the one sequence that offers a pair on purpose while an older pair is still in flight. Source registers that must stay free of hazards are taken from a range that no instruction writes.

// File: rtl/disc_pkg.sv
package disc_pkg;
  parameter int NUM_REGS  = 16;
  parameter int NUM_UNITS = 3;
  parameter int LAT_W     = 3;
  localparam int RW = $clog2(NUM_REGS);
  localparam int UW = $clog2(NUM_UNITS);

  typedef struct packed {
    logic [RW-1:0]    dst;
    logic             wr;
    logic [RW-1:0]    src_a;
    logic [RW-1:0]    src_b;
    logic [UW-1:0]    unit;
    logic [LAT_W-1:0] lat;
    logic             br;
  } instr_t;
endpackage

// File: rtl/disc_pair_buf.sv
module disc_pair_buf
  import disc_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       load,
  input  instr_t     in0,
  input  instr_t     in1,
  input  logic [1:0] clr,
  output logic [1:0] vld,
  output instr_t     slot0,
  output instr_t     slot1,
  output logic       empty
);
  always_ff @(posedge clk) begin
    if (rst) vld <= 2'b00;
    else if (load) vld <= 2'b11;
    else vld <= vld & ~clr;
  end

  // payload carries no reset; only the valid bits qualify it
  always_ff @(posedge clk) begin
    if (load) begin
      slot0 <= in0;
      slot1 <= in1;
    end
  end

  assign empty = (vld == 2'b00);
endmodule

// File: rtl/disc_issue_sel.sv
module disc_issue_sel
  import disc_pkg::*;
(
  input  logic [1:0]          vld,
  input  instr_t              s0,
  input  instr_t              s1,
  input  logic [LAT_W-1:0]    cnt [NUM_UNITS],
  input  logic [NUM_REGS-1:0] pending,
  input  logic                br_busy,
  output logic [1:0]          go
);
  logic free0, free1, ord0, ord1, ok0, ok1, pair_ok;

  always_comb begin
    free0 = 1'b1;
    free1 = 1'b1;
    ord0  = 1'b1;
    ord1  = 1'b1;
    for (int u = 0; u < NUM_UNITS; u++) begin
      if (s0.unit == UW'(u) && cnt[u] != '0) free0 = 1'b0;
      if (s1.unit == UW'(u) && cnt[u] != '0) free1 = 1'b0;
      if (cnt[u] > s0.lat) ord0 = 1'b0;
      if (cnt[u] > s1.lat) ord1 = 1'b0;
    end
    ok0 = free0 && ord0 && !br_busy
          && !pending[s0.src_a] && !pending[s0.src_b]
          && !(s0.wr && pending[s0.dst]);
    ok1 = free1 && ord1 && !br_busy
          && !pending[s1.src_a] && !pending[s1.src_b]
          && !(s1.wr && pending[s1.dst]);
    go[0] = vld[0] && ok0;
    pair_ok = go[0] && !s0.br
              && (s1.unit != s0.unit)
              && (s1.lat >= s0.lat)
              && !(s0.wr && (s1.src_a == s0.dst || s1.src_b == s0.dst))
              && !(s0.wr && s1.wr && s1.dst == s0.dst);
    go[1] = vld[1] && ok1 && (!vld[0] || pair_ok);
  end
endmodule

// File: rtl/disc_unit_track.sv
module disc_unit_track
  import disc_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 go0,
  input  logic                 go1,
  input  instr_t               ins0,
  input  instr_t               ins1,
  output logic [LAT_W-1:0]     cnt [NUM_UNITS],
  output logic                 br_busy,
  output logic [NUM_UNITS-1:0] done_wr,
  output logic [RW-1:0]        done_dst [NUM_UNITS],
  output logic [1:0]           wb_valid,
  output logic [RW-1:0]        wb_reg0,
  output logic [RW-1:0]        wb_reg1
);
  logic [NUM_UNITS-1:0] hit0, hit1, done, young_q, wr_q, brf_q;

  for (genvar u = 0; u < NUM_UNITS; u++) begin : g_unit
    assign hit0[u] = go0 && (ins0.unit == UW'(u));
    assign hit1[u] = go1 && (ins1.unit == UW'(u));
    assign done[u] = (cnt[u] == LAT_W'(1));
  end

  always_ff @(posedge clk) begin
    for (int u = 0; u < NUM_UNITS; u++) begin
      if (rst) begin
        cnt[u]      <= '0;
        brf_q[u]    <= 1'b0;
        wr_q[u]     <= 1'b0;
        young_q[u]  <= 1'b0;
        done_dst[u] <= '0;
      end else if (hit0[u]) begin
        cnt[u]      <= ins0.lat;
        brf_q[u]    <= ins0.br;
        wr_q[u]     <= ins0.wr;
        young_q[u]  <= 1'b0;
        done_dst[u] <= ins0.dst;
      end else if (hit1[u]) begin
        cnt[u]      <= ins1.lat;
        brf_q[u]    <= ins1.br;
        wr_q[u]     <= ins1.wr;
        young_q[u]  <= go0;
        done_dst[u] <= ins1.dst;
      end else if (cnt[u] != '0) begin
        cnt[u] <= cnt[u] - LAT_W'(1);
        if (done[u]) brf_q[u] <= 1'b0;
      end
    end
  end

  assign br_busy = |brf_q;
  assign done_wr = done & wr_q;

  // older finisher to port 0, the younger of a dual-issued pair to port 1
  logic          old_v, yng_v;
  logic [RW-1:0] old_d, yng_d;
  always_comb begin
    old_v = 1'b0;
    yng_v = 1'b0;
    old_d = '0;
    yng_d = '0;
    for (int u = 0; u < NUM_UNITS; u++) begin
      if (done_wr[u]) begin
        if (young_q[u]) begin
          yng_v = 1'b1;
          yng_d = done_dst[u];
        end else begin
          old_v = 1'b1;
          old_d = done_dst[u];
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wb_valid <= 2'b00;
      wb_reg0  <= '0;
      wb_reg1  <= '0;
    end else begin
      wb_valid <= {old_v && yng_v, old_v || yng_v};
      wb_reg0  <= old_v ? old_d : yng_d;
      wb_reg1  <= yng_d;
    end
  end
endmodule

// File: rtl/disc_scoreboard.sv
module disc_scoreboard
  import disc_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 go0,
  input  logic                 go1,
  input  instr_t               ins0,
  input  instr_t               ins1,
  input  logic [NUM_UNITS-1:0] done_wr,
  input  logic [RW-1:0]        done_dst [NUM_UNITS],
  output logic [NUM_REGS-1:0]  pending
);
  logic [NUM_REGS-1:0] set_m, clr_m;

  always_comb begin
    set_m = '0;
    clr_m = '0;
    for (int u = 0; u < NUM_UNITS; u++)
      if (done_wr[u]) clr_m[done_dst[u]] = 1'b1;
    if (go0 && ins0.wr) set_m[ins0.dst] = 1'b1;
    if (go1 && ins1.wr) set_m[ins1.dst] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) pending <= '0;
    else pending <= (pending & ~clr_m) | set_m;
  end
endmodule

// File: rtl/dual_issue_ctrl.sv
module dual_issue_ctrl
  import disc_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [RW-1:0]    s0_dst,
  input  logic             s0_wr,
  input  logic [RW-1:0]    s0_src_a,
  input  logic [RW-1:0]    s0_src_b,
  input  logic [UW-1:0]    s0_unit,
  input  logic [LAT_W-1:0] s0_lat,
  input  logic             s0_br,
  input  logic [RW-1:0]    s1_dst,
  input  logic             s1_wr,
  input  logic [RW-1:0]    s1_src_a,
  input  logic [RW-1:0]    s1_src_b,
  input  logic [UW-1:0]    s1_unit,
  input  logic [LAT_W-1:0] s1_lat,
  input  logic             s1_br,
  output logic [1:0]       iss_valid,
  output logic [UW-1:0]    iss_unit0,
  output logic [UW-1:0]    iss_unit1,
  output logic [1:0]       wb_valid,
  output logic [RW-1:0]    wb_reg0,
  output logic [RW-1:0]    wb_reg1
);
  instr_t               in0, in1, slot0, slot1;
  logic [1:0]           slot_vld, go;
  logic                 buf_empty, br_busy;
  logic [LAT_W-1:0]     unit_cnt [NUM_UNITS];
  logic [NUM_UNITS-1:0] done_wr;
  logic [RW-1:0]        done_dst [NUM_UNITS];
  logic [NUM_REGS-1:0]  pending;

  assign in0 = '{dst: s0_dst, wr: s0_wr, src_a: s0_src_a, src_b: s0_src_b,
                 unit: s0_unit, lat: s0_lat, br: s0_br};
  assign in1 = '{dst: s1_dst, wr: s1_wr, src_a: s1_src_a, src_b: s1_src_b,
                 unit: s1_unit, lat: s1_lat, br: s1_br};
  assign in_ready = buf_empty;

  disc_pair_buf u_buf (
    .clk(clk), .rst(rst), .load(in_valid && buf_empty),
    .in0(in0), .in1(in1), .clr(go),
    .vld(slot_vld), .slot0(slot0), .slot1(slot1), .empty(buf_empty)
  );

  disc_issue_sel u_sel (
    .vld(slot_vld), .s0(slot0), .s1(slot1), .cnt(unit_cnt),
    .pending(pending), .br_busy(br_busy), .go(go)
  );

  disc_unit_track u_units (
    .clk(clk), .rst(rst), .go0(go[0]), .go1(go[1]),
    .ins0(slot0), .ins1(slot1), .cnt(unit_cnt), .br_busy(br_busy),
    .done_wr(done_wr), .done_dst(done_dst),
    .wb_valid(wb_valid), .wb_reg0(wb_reg0), .wb_reg1(wb_reg1)
  );

  disc_scoreboard u_sb (
    .clk(clk), .rst(rst), .go0(go[0]), .go1(go[1]),
    .ins0(slot0), .ins1(slot1), .done_wr(done_wr), .done_dst(done_dst),
    .pending(pending)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      iss_valid <= 2'b00;
      iss_unit0 <= '0;
      iss_unit1 <= '0;
    end else begin
      iss_valid <= go;
      iss_unit0 <= slot0.unit;
      iss_unit1 <= slot1.unit;
    end
  end
endmodule

// File: rtl/dual_issue_ctrl_chk.sv
module dual_issue_ctrl_chk
  import disc_pkg::*;
(
  input logic          clk,
  input logic          rst,
  input logic          in_valid,
  input logic          in_ready,
  input logic [1:0]    iss_valid,
  input logic [UW-1:0] iss_unit0,
  input logic [UW-1:0] iss_unit1,
  input logic [1:0]    wb_valid,
  input logic [1:0]    slot_vld,
  input logic [1:0]    go,
  input logic          br_busy
);
  p_take_pair_r1: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready) |=> !in_ready);

  p_older_first_r2: assert property (@(posedge clk) disable iff (rst)
    (iss_valid == 2'b10) |-> !$past(slot_vld[0]));

  p_pair_units_r3: assert property (@(posedge clk) disable iff (rst)
    (iss_valid == 2'b11) |-> (iss_unit0 != iss_unit1));

  p_branch_hold_r7: assert property (@(posedge clk) disable iff (rst)
    br_busy |-> (go == 2'b00));

  p_wb_ports_r8: assert property (@(posedge clk) disable iff (rst)
    wb_valid[1] |-> wb_valid[0]);
endmodule

bind dual_issue_ctrl dual_issue_ctrl_chk u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
  .iss_valid(iss_valid), .iss_unit0(iss_unit0), .iss_unit1(iss_unit1),
  .wb_valid(wb_valid), .slot_vld(slot_vld), .go(go), .br_busy(br_busy)
);

// File: tb/dual_issue_ctrl_bench.sv
`timescale 1ns/1ps
module dual_issue_ctrl_bench;
  import disc_pkg::*;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2.5 clk = ~clk;

  logic             in_valid = 1'b0, in_ready;
  logic [RW-1:0]    s0_dst = '0, s0_src_a = '0, s0_src_b = '0;
  logic [RW-1:0]    s1_dst = '0, s1_src_a = '0, s1_src_b = '0;
  logic             s0_wr = 1'b0, s0_br = 1'b0, s1_wr = 1'b0, s1_br = 1'b0;
  logic [UW-1:0]    s0_unit = '0, s1_unit = '0, iss_unit0, iss_unit1;
  logic [LAT_W-1:0] s0_lat = '0, s1_lat = '0;
  logic [1:0]       iss_valid, wb_valid;
  logic [RW-1:0]    wb_reg0, wb_reg1;

  dual_issue_ctrl u_dual_issue_ctrl (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .s0_dst(s0_dst), .s0_wr(s0_wr), .s0_src_a(s0_src_a), .s0_src_b(s0_src_b),
    .s0_unit(s0_unit), .s0_lat(s0_lat), .s0_br(s0_br),
    .s1_dst(s1_dst), .s1_wr(s1_wr), .s1_src_a(s1_src_a), .s1_src_b(s1_src_b),
    .s1_unit(s1_unit), .s1_lat(s1_lat), .s1_br(s1_br),
    .iss_valid(iss_valid), .iss_unit0(iss_unit0), .iss_unit1(iss_unit1),
    .wb_valid(wb_valid), .wb_reg0(wb_reg0), .wb_reg1(wb_reg1)
  );

  int tests = 0, fails = 0;
  int t_iss0, t_iss1, t_wb0, t_wb1, t_rdy, n_wb, pair_p0, pair_p1;

  task automatic chk(input string tag, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // called at a falling edge; returns at the falling edge after the accept edge
  task automatic drive(input int d0, w0, a0, b0, u0, l0, br0,
                       input int d1, w1, a1, b1, u1, l1, br1);
    s0_dst = RW'(d0); s0_wr = w0[0]; s0_src_a = RW'(a0); s0_src_b = RW'(b0);
    s0_unit = UW'(u0); s0_lat = LAT_W'(l0); s0_br = br0[0];
    s1_dst = RW'(d1); s1_wr = w1[0]; s1_src_a = RW'(a1); s1_src_b = RW'(b1);
    s1_unit = UW'(u1); s1_lat = LAT_W'(l1); s1_br = br1[0];
    in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  // k = 1 is the first cycle after the accept edge
  task automatic watch(input int d0, input int d1);
    t_iss0 = -1; t_iss1 = -1; t_wb0 = -1; t_wb1 = -1; t_rdy = -1;
    n_wb = 0; pair_p0 = -1; pair_p1 = -1;
    for (int k = 1; k <= 40; k++) begin
      if (iss_valid[0] && t_iss0 < 0) t_iss0 = k;
      if (iss_valid[1] && t_iss1 < 0) t_iss1 = k;
      if (in_ready && t_rdy < 0) t_rdy = k;
      if (wb_valid[0]) begin
        n_wb++;
        if (int'(wb_reg0) == d0 && t_wb0 < 0) t_wb0 = k;
        else if (int'(wb_reg0) == d1 && t_wb1 < 0) t_wb1 = k;
      end
      if (wb_valid[1]) begin
        n_wb++;
        if (int'(wb_reg1) == d1 && t_wb1 < 0) t_wb1 = k;
        else if (int'(wb_reg1) == d0 && t_wb0 < 0) t_wb0 = k;
      end
      if (wb_valid == 2'b11) begin
        pair_p0 = int'(wb_reg0);
        pair_p1 = int'(wb_reg1);
      end
      @(negedge clk);
    end
  endtask

  initial begin
    #(100000 * 5);
    fails++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 reset in_ready", int'(in_ready), 1);
    chk("R1 reset iss_valid", int'(iss_valid), 0);
    chk("R1 reset wb_valid", int'(wb_valid), 0);

    // independent pair on units 0 and 1, every latency combination
    for (int l0 = 1; l0 <= 4; l0++) begin
      for (int l1 = 1; l1 <= 4; l1++) begin
        drive(1, 1, 10, 11, 0, l0, 0, 2, 1, 12, 13, 1, l1, 0);
        watch(1, 2);
        chk("R2 slot0 first decision", t_iss0, 2);
        chk("R4 slot1 offset", t_iss1 - t_iss0, (l1 >= l0) ? 0 : l0 - l1 + 1);
        chk("R8 slot0 wb delay", t_wb0 - t_iss0, l0);
        chk("R8 slot1 wb delay", t_wb1 - t_iss1, l1);
        chk("R1 ready after pair", t_rdy, t_iss1);
        if (l0 == l1) begin
          chk("R8 port0 older", pair_p0, 1);
          chk("R8 port1 younger", pair_p1, 2);
        end
      end
    end

    // same unit for both slots
    for (int l = 1; l <= 4; l++) begin
      drive(1, 1, 10, 11, 2, l, 0, 2, 1, 12, 13, 2, l, 0);
      watch(1, 2);
      chk("R3 unit conflict offset", t_iss1 - t_iss0, l + 1);
      chk("R1 ready held", t_rdy, t_iss1);
    end

    // read after write inside the pair (source a, then source b)
    for (int l = 1; l <= 4; l++) begin
      drive(3, 1, 10, 11, 0, l, 0, 4, 1, 3, 13, 1, l, 0);
      watch(3, 4);
      chk("R5 raw src_a offset", t_iss1 - t_iss0, l + 1);
    end
    drive(3, 1, 10, 11, 0, 2, 0, 4, 1, 12, 3, 1, 3, 0);
    watch(3, 4);
    chk("R5 raw src_b offset", t_iss1 - t_iss0, 3);

    // same destination inside the pair
    for (int l = 1; l <= 3; l++) begin
      drive(5, 1, 10, 11, 0, l, 0, 5, 1, 12, 13, 1, l, 0);
      watch(5, 15);
      chk("R6 waw offset", t_iss1 - t_iss0, l + 1);
      chk("R6 waw two writes", n_wb, 2);
    end

    // branch in slot 0, not writing
    for (int l = 1; l <= 3; l++) begin
      drive(6, 0, 10, 11, 1, l, 1, 2, 1, 12, 13, 2, l, 0);
      watch(6, 2);
      chk("R7 branch offset", t_iss1 - t_iss0, l + 1);
      chk("R8 no wb without write flag", n_wb, 1);
      chk("R8 no wb of branch reg", t_wb0, -1);
    end

    // second pair offered while the first is in flight
    drive(5, 1, 10, 11, 0, 4, 0, 6, 1, 12, 13, 1, 4, 0);
    while (!in_ready) @(negedge clk);
    drive(7, 1, 5, 11, 0, 4, 0, 8, 1, 10, 11, 2, 4, 0);
    watch(7, 8);
    chk("R5 cross pair raw", t_iss0, 5);
    chk("R2 younger waits for older", t_iss1, 5);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule